// File: doc/BRIEF.md
# Event Timer Register File and Main Counter

This block is the software-visible front of a multi-channel event timer. It owns the free-running 64-bit main counter and holds every register that software sets up. These are one global capability word, one global configuration word, an interrupt status word, and a configuration, comparator and routing word for each channel. Neighbouring blocks read the counter, the configuration fields and the status bits from its output ports. A channel comparison block and an interrupt output block use these values, and the comparison block reports matches back on `ch_hit`.

Requests arrive on a simple single-cycle valid/write/address/data port. An access is 4 or 8 bytes. Address bit 2 picks the upper half of a 64-bit register for 4-byte accesses, and a 4-byte write changes only that half. A read answers one clock after the request with `rsp_valid` high. Writes give no response.

The counter counts only while the global run bit is set. While it is clear, the counter holds its value and software may load a new one. Setting the run bit again resumes counting from the held value.

Top module: `et_register_file`

## Requirements
- R1: After reset, the following values hold. The global configuration, the main counter and the status word are zero. Each channel configuration reads `{ROUTE_CAP, 32'h0000_0030}`. Each comparator reads all ones, and each routing word reads zero.
- R2: The capability register at 0x000 reads as follows. The low word is 0x8086A001 with NUM_CH−1 placed in bits 12:8, and the high word is TICK_FS, the counter tick period in femtoseconds. Writes to it have no effect.
- R3: A wide access (`req_wide`=1) moves all 64 bits. A narrow access uses address bit 2 to select the upper (1) or lower (0) half. A narrow write replaces only that half, and a narrow read returns the half in `rsp_rdata[31:0]` with bits 63:32 zero.
- R4: The global configuration at 0x010 has two writable bits: bit 0 is the run bit and bit 1 is the legacy-route bit. All other bits read zero whatever is written.
- R5: Channel configuration writes pass through a mask. The writable bits are 1, 2, 3, 6, 8, 9–13 and 14. Bits 4 and 5 always read one, bits 63:32 always read ROUTE_CAP, and the remaining bits read zero.
- R6: While the run bit is set, the main counter (`main_count` and register 0x0F0) increases by exactly one every clock.
- R7: While the run bit is clear, the main counter holds its value and may be written at 0x0F0/0x0F4. A counter write while the run bit is set is ignored. Setting the run bit resumes counting from the held value.
- R8: Channel n's registers start at 0x100 + 0x20·n. Address bits 4:3 select the configuration (0), the comparator (1) or the routing word (2). Selection 3 reads zero.
- R9: An access to a channel index at or above NUM_CH reads zero, and its write changes no register.
- R10: While channel configuration bit 8 (32-bit mode) is set, the following hold. The comparator's upper 32 bits are zero. A narrow write to the comparator's upper half is dropped, and a comparator write stores only the low 32 bits. Setting bit 8 clears the comparator's upper half.
- R11: Status bit n at 0x020 is set by a pulse on `ch_hit[n]` and cleared by writing one to it. A hit in the same cycle as a clear leaves the bit set.
- R12: A read request produces `rsp_valid` and its data exactly one clock later. A write produces no `rsp_valid`. Unmapped global addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_addr | input | 10 | Byte address |
| req_wdata | input | 64 | Write data (low 32 bits used for narrow writes) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| ch_hit | input | NUM_CH | Match pulses from the comparison block |
| main_count | output | 64 | Main counter value |
| run_enable | output | 1 | Global run bit |
| legacy_route | output | 1 | Global legacy-route bit |
| irq_status | output | NUM_CH | Status bits per channel |
| ch_cfg_flat | output | 64·NUM_CH | Channel configurations, channel n at bits 64n+63:64n |
| ch_cmp_flat | output | 64·NUM_CH | Channel comparators |
| ch_route_flat | output | 64·NUM_CH | Channel routing words |

## Verification
The register path is tested with a series of patterns. Writing all ones to the channel configuration exposes the write mask and any fixed bit that can be overwritten. Narrow writes to each half tell merging apart from overwriting, and wide reads of the same register confirm the result. Accesses in 32-bit comparator mode show whether the upper-half drop and clear are done. Channel 3 and selection 3 are used to expose aliasing into implemented channels.

The counter is loaded while stopped and is then checked to hold. It is then run for a known number of cycles while a write is attempted in between, which separates "ignored while running" from "loaded". The status word sees a hit alone, a clear alone, and a hit together with a clear, which shows the priority.

// File: rtl/et_regs_pkg.sv
package et_regs_pkg;

  // Global register word addresses (byte address with bits 2:0 cleared)
  localparam logic [9:0] GA_CAPS   = 10'h000;
  localparam logic [9:0] GA_CTRL   = 10'h010;
  localparam logic [9:0] GA_STATUS = 10'h020;
  localparam logic [9:0] GA_COUNT  = 10'h0F0;

  // Global control bits
  localparam int CTRL_RUN    = 0;
  localparam int CTRL_LEGACY = 1;
  localparam logic [63:0] CTRL_WMASK = 64'h3;

  // Channel configuration bits (decoded by neighbour blocks)
  localparam int CH_MODE32 = 8;
  localparam logic [63:0] CH_WMASK = 64'h0000_0000_0000_7F4E;
  localparam logic [31:0] CH_FIXED = 32'h0000_0030;

  typedef enum logic [1:0] {SEL_CFG = 2'd0, SEL_CMP = 2'd1, SEL_ROUTE = 2'd2, SEL_NONE = 2'd3} ch_sel_e;

  // Place a 4- or 8-byte write into a 64-bit register
  function automatic logic [63:0] merge_word(input logic [63:0] old, input logic [63:0] wdata,
                                             input logic wide, input logic hi);
    if (wide)    return wdata;
    else if (hi) return {wdata[31:0], old[31:0]};
    else         return {old[63:32], wdata[31:0]};
  endfunction

endpackage

// File: rtl/et_main_counter.sv
module et_main_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] value
);

  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (run)  value <= value + W'(1);
    else if (load) value <= load_val;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    run |=> value == $past(value) + W'(1)); // R6

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> value == $past(value)); // R7

endmodule

// File: rtl/et_channel_regs.sv
module et_channel_regs
  import et_regs_pkg::*;
#(
  parameter logic [31:0] ROUTE_CAP = 32'h00F0_0004
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_cfg,
  input  logic        wr_cmp,
  input  logic        wr_route,
  input  logic        wr_wide,
  input  logic        wr_hi,
  input  logic [63:0] wr_data,
  output logic [63:0] cfg_q,
  output logic [63:0] cmp_q,
  output logic [63:0] route_q
);

  logic [63:0] cfg_merged, cfg_next;

  always_comb begin
    cfg_merged = merge_word(cfg_q, wr_data, wr_wide, wr_hi);
    cfg_next   = (cfg_merged & CH_WMASK) | {ROUTE_CAP, CH_FIXED};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= {ROUTE_CAP, CH_FIXED};
      cmp_q   <= '1;
      route_q <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_q <= cfg_next;
        if (cfg_next[CH_MODE32]) cmp_q[63:32] <= '0;
      end
      if (wr_cmp) begin
        if (cfg_q[CH_MODE32]) begin
          if (wr_wide || !wr_hi) cmp_q <= {32'h0, wr_data[31:0]};
        end else begin
          cmp_q <= merge_word(cmp_q, wr_data, wr_wide, wr_hi);
        end
      end
      if (wr_route) route_q <= merge_word(route_q, wr_data, wr_wide, wr_hi);
    end
  end

  AST_CFG_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    wr_cfg |=> (cfg_q[63:32] == ROUTE_CAP) && (cfg_q[5:4] == 2'b11)); // R5

  AST_CMP32_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_q[CH_MODE32] |-> cmp_q[63:32] == 32'h0); // R10

endmodule

// File: rtl/et_register_file.sv
module et_register_file
  import et_regs_pkg::*;
#(
  parameter int          NUM_CH    = 3,
  parameter logic [31:0] TICK_FS   = 32'd8000000,
  parameter logic [31:0] ROUTE_CAP = 32'h00F0_0004
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_wide,
  input  logic [9:0]           req_addr,
  input  logic [63:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [63:0]          rsp_rdata,
  input  logic [NUM_CH-1:0]    ch_hit,
  output logic [63:0]          main_count,
  output logic                 run_enable,
  output logic                 legacy_route,
  output logic [NUM_CH-1:0]    irq_status,
  output logic [64*NUM_CH-1:0] ch_cfg_flat,
  output logic [64*NUM_CH-1:0] ch_cmp_flat,
  output logic [64*NUM_CH-1:0] ch_route_flat
);

  localparam int          IDX_W    = 5;
  localparam logic [IDX_W-1:0] CH_LIMIT = IDX_W'(NUM_CH);
  localparam logic [31:0] CAPS_LO  = 32'h8086_A001 | (32'(NUM_CH - 1) << 8);
  localparam logic [63:0] CAPS     = {TICK_FS, CAPS_LO};

  // ---------------- decode ----------------
  logic             in_ch, ch_ok, hi, wr, rd;
  logic [IDX_W-1:0] ch_idx;
  ch_sel_e          sel;
  logic [9:0]       gword;

  always_comb begin
    in_ch  = req_addr[9:8] != 2'b00;
    ch_idx = req_addr[9:5] - IDX_W'(8);
    ch_ok  = in_ch && (ch_idx < CH_LIMIT);
    sel    = ch_sel_e'(req_addr[4:3]);
    hi     = req_addr[2];
    gword  = {req_addr[9:3], 3'b000};
    wr     = req_valid && req_write;
    rd     = req_valid && !req_write;
  end

  // ---------------- global control ----------------
  logic [63:0] ctrl_q;
  logic [63:0] clr_vec;

  always_comb begin
    if (req_wide)  clr_vec = req_wdata;
    else if (hi)   clr_vec = {req_wdata[31:0], 32'h0};
    else           clr_vec = {32'h0, req_wdata[31:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      irq_status <= '0;
    end else begin
      if (wr && !in_ch && gword == GA_CTRL)
        ctrl_q <= merge_word(ctrl_q, req_wdata, req_wide, hi) & CTRL_WMASK;
      if (wr && !in_ch && gword == GA_STATUS)
        irq_status <= (irq_status & ~clr_vec[NUM_CH-1:0]) | ch_hit;
      else
        irq_status <= irq_status | ch_hit;
    end
  end

  assign run_enable   = ctrl_q[CTRL_RUN];
  assign legacy_route = ctrl_q[CTRL_LEGACY];

  // ---------------- main counter ----------------
  logic cnt_load;
  assign cnt_load = wr && !in_ch && gword == GA_COUNT && !run_enable;

  et_main_counter #(.W(64)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .run      (run_enable),
    .load     (cnt_load),
    .load_val (merge_word(main_count, req_wdata, req_wide, hi)),
    .value    (main_count)
  );

  // ---------------- channels ----------------
  logic [63:0] cfg_a   [NUM_CH];
  logic [63:0] cmp_a   [NUM_CH];
  logic [63:0] route_a [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit_me;
    assign hit_me = wr && ch_ok && (ch_idx == IDX_W'(i));

    et_channel_regs #(.ROUTE_CAP(ROUTE_CAP)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr_cfg   (hit_me && sel == SEL_CFG),
      .wr_cmp   (hit_me && sel == SEL_CMP),
      .wr_route (hit_me && sel == SEL_ROUTE),
      .wr_wide  (req_wide),
      .wr_hi    (hi),
      .wr_data  (req_wdata),
      .cfg_q    (cfg_a[i]),
      .cmp_q    (cmp_a[i]),
      .route_q  (route_a[i])
    );

    assign ch_cfg_flat[64*i +: 64]   = cfg_a[i];
    assign ch_cmp_flat[64*i +: 64]   = cmp_a[i];
    assign ch_route_flat[64*i +: 64] = route_a[i];
  end

  // ---------------- read path ----------------
  logic [63:0] rd_word, rd_out;

  always_comb begin
    rd_word = '0;
    if (in_ch) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_ok && ch_idx == IDX_W'(i)) begin
          unique case (sel)
            SEL_CFG:   rd_word = cfg_a[i];
            SEL_CMP:   rd_word = cmp_a[i];
            SEL_ROUTE: rd_word = route_a[i];
            default:   rd_word = '0;
          endcase
        end
      end
    end else begin
      case (gword)
        GA_CAPS:   rd_word = CAPS;
        GA_CTRL:   rd_word = ctrl_q;
        GA_STATUS: rd_word = 64'(irq_status);
        GA_COUNT:  rd_word = main_count;
        default:   rd_word = '0;
      endcase
    end
    if (req_wide)  rd_out = rd_word;
    else if (hi)   rd_out = {32'h0, rd_word[63:32]};
    else           rd_out = {32'h0, rd_word[31:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_out;
    end
  end

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    rd |=> rsp_valid); // R12

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rsp_valid); // R12

  AST_OOR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && in_ch && !ch_ok) |=> rsp_rdata == 64'h0); // R9

  AST_HIT_WINS: assert property (@(posedge clk) disable iff (rst)
    (ch_hit != '0) |=> (irq_status & $past(ch_hit)) == $past(ch_hit)); // R11

endmodule

// File: tb/et_register_file_tb_top.sv
`timescale 1ns/1ps
module et_register_file_tb_top;

  localparam int NUM_CH = 3;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [9:0]           req_addr = '0;
  logic [63:0]          req_wdata = '0;
  logic                 rsp_valid;
  logic [63:0]          rsp_rdata;
  logic [NUM_CH-1:0]    ch_hit = '0;
  logic [63:0]          main_count;
  logic                 run_enable, legacy_route;
  logic [NUM_CH-1:0]    irq_status;
  logic [64*NUM_CH-1:0] ch_cfg_flat, ch_cmp_flat, ch_route_flat;

  always #4 clk = ~clk;

  et_register_file #(.NUM_CH(NUM_CH), .TICK_FS(32'd8000000), .ROUTE_CAP(32'h00F0_0004)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ch_hit(ch_hit), .main_count(main_count), .run_enable(run_enable), .legacy_route(legacy_route),
    .irq_status(irq_status), .ch_cfg_flat(ch_cfg_flat), .ch_cmp_flat(ch_cmp_flat),
    .ch_route_flat(ch_route_flat)
  );

  typedef struct packed {
    logic        wr;
    logic        wide;
    logic [9:0]  addr;
    logic [63:0] data;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 10'h000, 64'h0, 64'h007A1200_8086A201, 4'd2},              // R2
    '{1'b1, 1'b1, 10'h000, 64'hFFFFFFFF_FFFFFFFF, 64'h0, 4'd2},               // R2 write ignored
    '{1'b0, 1'b1, 10'h000, 64'h0, 64'h007A1200_8086A201, 4'd2},
    '{1'b0, 1'b0, 10'h004, 64'h0, 64'h00000000_007A1200, 4'd3},               // R3 narrow high read
    '{1'b0, 1'b1, 10'h100, 64'h0, 64'h00F00004_00000030, 4'd1},               // R1
    '{1'b0, 1'b1, 10'h108, 64'h0, 64'hFFFFFFFF_FFFFFFFF, 4'd1},
    '{1'b0, 1'b1, 10'h110, 64'h0, 64'h0, 4'd1},
    '{1'b1, 1'b1, 10'h100, 64'hFFFFFFFF_FFFFFFFF, 64'h0, 4'd5},               // R5 mask
    '{1'b0, 1'b1, 10'h100, 64'h0, 64'h00F00004_00007F7E, 4'd5},
    '{1'b0, 1'b1, 10'h108, 64'h0, 64'h00000000_FFFFFFFF, 4'd10},              // R10 upper cleared
    '{1'b1, 1'b0, 10'h10C, 64'h12345678, 64'h0, 4'd10},
    '{1'b0, 1'b1, 10'h108, 64'h0, 64'h00000000_FFFFFFFF, 4'd10},              // R10 upper write dropped
    '{1'b1, 1'b0, 10'h100, 64'h0, 64'h0, 4'd5},
    '{1'b1, 1'b0, 10'h10C, 64'hAABBCCDD, 64'h0, 4'd3},
    '{1'b0, 1'b1, 10'h108, 64'h0, 64'hAABBCCDD_FFFFFFFF, 4'd3},               // R3 merge high half
    '{1'b1, 1'b1, 10'h150, 64'h11223344_55667788, 64'h0, 4'd8},               // R8 ch2 route
    '{1'b0, 1'b0, 10'h154, 64'h0, 64'h00000000_11223344, 4'd8},
    '{1'b1, 1'b1, 10'h168, 64'h0, 64'h0, 4'd9},                               // R9 ch3 write
    '{1'b0, 1'b1, 10'h168, 64'h0, 64'h0, 4'd9},
    '{1'b0, 1'b1, 10'h160, 64'h0, 64'h0, 4'd9},
    '{1'b0, 1'b1, 10'h108, 64'h0, 64'hAABBCCDD_FFFFFFFF, 4'd9},               // R9 no alias
    '{1'b0, 1'b1, 10'h118, 64'h0, 64'h0, 4'd8},                               // R8 sel 3
    '{1'b1, 1'b1, 10'h010, 64'hFFFFFFFF_FFFFFFFE, 64'h0, 4'd4},               // R4
    '{1'b0, 1'b1, 10'h010, 64'h0, 64'h2, 4'd4},
    '{1'b1, 1'b1, 10'h010, 64'h0, 64'h0, 4'd4},
    '{1'b0, 1'b1, 10'h030, 64'h0, 64'h0, 4'd12},                              // R12 unmapped
    '{1'b0, 1'b0, 10'h124, 64'h0, 64'h00000000_00F00004, 4'd1}                // R1 ch1 high
  };

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Call at a falling edge; returns at the next falling edge with the response
  task automatic bus(input logic wr, input logic wide, input logic [9:0] addr,
                     input logic [63:0] data, output logic [63:0] rdata, output logic rvalid);
    req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = addr; req_wdata = data;
    @(negedge clk);
    rvalid = rsp_valid; rdata = rsp_rdata;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    logic [63:0] rd;
    logic        rv;
    logic [63:0] prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state at the ports
    check("R1 count", main_count, 64'h0);
    check("R1 run", {63'h0, run_enable}, 64'h0);
    check("R1 status", 64'(irq_status), 64'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      bus(VEC[i].wr, VEC[i].wide, VEC[i].addr, VEC[i].data, rd, rv);
      if (VEC[i].wr) begin
        check("R12 write gives no response", {63'h0, rv}, 64'h0);
      end else begin
        check("R12 read response valid", {63'h0, rv}, 64'h1);
        check($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].exp);
      end
    end

    // R7 load while stopped, then hold
    bus(1'b1, 1'b1, 10'h0F0, 64'd100, rd, rv);
    bus(1'b0, 1'b1, 10'h0F0, 64'h0, rd, rv);
    check("R7 loaded value", rd, 64'd100);
    repeat (5) @(negedge clk);
    check("R7 held while stopped", main_count, 64'd100);

    // R6 / R7 run for 10 edges with an ignored write inside
    bus(1'b1, 1'b1, 10'h010, 64'h1, rd, rv);
    bus(1'b1, 1'b1, 10'h0F0, 64'h0, rd, rv);
    for (int k = 0; k < 8; k++) begin
      prev = main_count;
      @(negedge clk);
      check("R6 step of one", main_count, prev + 64'd1);
    end
    bus(1'b1, 1'b1, 10'h010, 64'h0, rd, rv);
    check("R7 write while running ignored", main_count, 64'd110);
    bus(1'b0, 1'b1, 10'h0F0, 64'h0, rd, rv);
    check("R7 read after halt", rd, 64'd110);

    // R3 narrow counter write to the upper half
    bus(1'b1, 1'b0, 10'h0F4, 64'h1, rd, rv);
    bus(1'b0, 1'b0, 10'h0F0, 64'h0, rd, rv);
    check("R3 low half kept", rd, 64'd110);
    bus(1'b0, 1'b1, 10'h0F0, 64'h0, rd, rv);
    check("R3 merged counter", rd, 64'h00000001_0000006E);

    // R11 status set, clear, and set-over-clear
    ch_hit = 3'b101;
    @(negedge clk);
    ch_hit = 3'b000;
    bus(1'b0, 1'b1, 10'h020, 64'h0, rd, rv);
    check("R11 set by hit", rd, 64'h5);
    bus(1'b1, 1'b1, 10'h020, 64'h1, rd, rv);
    bus(1'b0, 1'b1, 10'h020, 64'h0, rd, rv);
    check("R11 write one clears", rd, 64'h4);
    ch_hit = 3'b100;
    bus(1'b1, 1'b1, 10'h020, 64'h4, rd, rv);
    ch_hit = 3'b000;
    bus(1'b0, 1'b1, 10'h020, 64'h0, rd, rv);
    check("R11 hit wins over clear", rd, 64'h4);
    bus(1'b1, 1'b0, 10'h020, 64'h4, rd, rv);
    check("R11 status port cleared", 64'(irq_status), 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule